// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (Subset)

This block is a single-cycle processor that runs a reduced set of the 32-bit RISC-V base integer instructions: enough for arithmetic, memory traffic and loops such as summing an array. It holds 32 general registers of 32 bits, a program counter, a word-organised instruction store and a word-organised data store. Every instruction is fetched, decoded, executed and retired in a single clock.

Both stores are filled through one load stream before execution starts. The stream follows valid/ready rules. `ld_ready` is high only while `rst` is high, so a beat is accepted on a clock edge where `ld_valid` and `ld_ready` are both high. A producer that raises `ld_valid` while the core runs is back-pressured for as long as the core runs, and nothing is written. Once reset falls, the core executes from address 0 until it fetches the stop word or an instruction it cannot decode. It then freezes and raises `halted`. A combinational debug port reads any register at any time.

Top module: `rvs_core`

## Requirements
- R1: Register 0 always reads as zero. A write that targets register 0 is dropped.
- R2: Opcode 0110011 with funct7 0000000 performs add (funct3 000), slt (funct3 010, signed less-than giving 1 or 0), or (funct3 110) and and (funct3 111). With funct7 0100000 and funct3 000 it performs sub. The result goes to rd.
- R3: Opcode 0010011 with funct3 000 (addi) adds the sign-extended 12-bit field from bits 31:20 to rs1 and writes rd.
- R4: Opcode 0110111 (lui) writes bits 31:12 of the instruction into bits 31:12 of rd and zeroes bits 11:0. For example, 0xffff gives 0x0ffff000.
- R5: lw (opcode 0000011, funct3 010) and sw (opcode 0100011, funct3 010) address memory at rs1 plus a sign-extended 12-bit offset. Byte address bits 11:2 select the word. lw writes rd, and sw stores rs2.
- R6: After reset the PC is 0, `halted` and `illegal` are low and every register is zero. An instruction that does not transfer control advances the PC by 4.
- R7: Opcode 1100011 with funct3 000 (beq) or 001 (bne) compares rs1 with rs2. When the condition holds, the PC moves to PC plus the sign-extended B-format offset. Otherwise it moves to PC+4.
- R8: Opcode 1101111 (jal) writes PC+4 to rd and moves the PC to PC plus the sign-extended J-format offset.
- R9: Fetching 0x00000073 stops the core with no register or memory write. `halted` rises on the next edge, the PC stays on that word, and no later instruction runs.
- R10: Any opcode or funct combination not listed above makes no write. It sets `illegal` and `halted` on the next edge and freezes the PC on that word.
- R11: `ld_ready` equals `rst`. An accepted beat writes `ld_data` at word index `ld_addr`, into the data store when `ld_dmem` is 1 and into the instruction store when it is 0.
- R12: `dbg_data` shows the register selected by `dbg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; load window |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat can be accepted (high during reset) |
| ld_dmem | input | 1 | 1 selects data store, 0 instruction store |
| ld_addr | input | LOAD_AW | Word index of the load beat |
| ld_data | input | 32 | Word to write |
| dbg_addr | input | 5 | Register to observe |
| dbg_data | output | 32 | Value of the selected register |
| pc | output | 32 | Current program counter |
| halted | output | 1 | Core stopped |
| illegal | output | 1 | Stop caused by an undecodable instruction |

## Verification
The bench builds the core with its default sizes: 256 instruction words, 1024 data words and a 10-bit load index. With the full 10-bit data index, byte addresses up to 0xffc can be reached, so the array-sum program places its descriptor at 0x100 and its array at 0x200 and still exercises a negative load offset. The 256-word instruction store leaves room for the loop, the forward branch, the jump with its link value, the stop word and an instruction placed after it. Random operand pairs, including equal, sign-boundary and extreme values, are built with lui and addi. They reach every ALU result, the signed-compare edge and lui values with the top bit set.

// File: rtl/rvs_pkg.sv
`timescale 1ns/1ps
package rvs_pkg;
  localparam logic [6:0] OP_REG  = 7'b0110011;
  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_LOAD = 7'b0000011;
  localparam logic [6:0] OP_STOR = 7'b0100011;
  localparam logic [6:0] OP_BRAN = 7'b1100011;
  localparam logic [6:0] OP_LUI  = 7'b0110111;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [31:0] STOP_WORD = 32'h0000_0073;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_PASSB
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    alu_op_e alu_op;
    logic    use_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    br_ne;
    logic    jump;
    logic    stop;
    logic    bad;
  } ctrl_t;
endpackage

// File: rtl/rvs_decode.sv
`timescale 1ns/1ps
module rvs_decode
  import rvs_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctl,
  output logic [31:0] imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    imm = {{20{instr[31]}}, instr[31:20]};
    if (instr == STOP_WORD) begin
      ctl.stop = 1'b1;
    end else begin
      unique case (opc)
        OP_REG: begin
          ctl.reg_we = 1'b1;
          if (f7 == 7'b0000000 && f3 == 3'b000)      ctl.alu_op = ALU_ADD;
          else if (f7 == 7'b0100000 && f3 == 3'b000) ctl.alu_op = ALU_SUB;
          else if (f7 == 7'b0000000 && f3 == 3'b111) ctl.alu_op = ALU_AND;
          else if (f7 == 7'b0000000 && f3 == 3'b110) ctl.alu_op = ALU_OR;
          else if (f7 == 7'b0000000 && f3 == 3'b010) ctl.alu_op = ALU_SLT;
          else ctl.bad = 1'b1;
        end
        OP_IMM: begin
          ctl.reg_we  = 1'b1;
          ctl.use_imm = 1'b1;
          ctl.bad     = (f3 != 3'b000);
        end
        OP_LOAD: begin
          ctl.reg_we  = 1'b1;
          ctl.use_imm = 1'b1;
          ctl.mem_rd  = 1'b1;
          ctl.bad     = (f3 != 3'b010);
        end
        OP_STOR: begin
          ctl.use_imm = 1'b1;
          ctl.mem_wr  = 1'b1;
          ctl.bad     = (f3 != 3'b010);
          imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
        end
        OP_BRAN: begin
          ctl.branch = 1'b1;
          ctl.br_ne  = f3[0];
          ctl.bad    = (f3[2:1] != 2'b00);
          imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
        end
        OP_LUI: begin
          ctl.reg_we  = 1'b1;
          ctl.use_imm = 1'b1;
          ctl.alu_op  = ALU_PASSB;
          imm = {instr[31:12], 12'b0};
        end
        OP_JAL: begin
          ctl.reg_we = 1'b1;
          ctl.jump   = 1'b1;
          imm = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
        end
        default: ctl.bad = 1'b1;
      endcase
      if (ctl.bad) begin
        ctl.reg_we = 1'b0;
        ctl.mem_wr = 1'b0;
        ctl.branch = 1'b0;
        ctl.jump   = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rvs_alu.sv
`timescale 1ns/1ps
module rvs_alu
  import rvs_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         eq
);
  assign eq = (a == c);
  always_comb begin
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_SLT:   y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/rvs_regfile.sv
`timescale 1ns/1ps
module rvs_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;
  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                     regs[g] <= '0;
      else if (we && wa == AW'(g)) regs[g] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];

  // R1
  rf_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));
  // R1
  rf_zero_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> rd3 == '0 || ra3 != '0);
endmodule

// File: rtl/rvs_core.sv
`timescale 1ns/1ps
module rvs_core
  import rvs_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 1024,
  parameter int LOAD_AW    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic               ld_dmem,
  input  logic [LOAD_AW-1:0] ld_addr,
  input  logic [31:0]        ld_data,
  input  logic [4:0]         dbg_addr,
  output logic [31:0]        dbg_data,
  output logic [31:0]        pc,
  output logic               halted,
  output logic               illegal
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] pc_q, instr, imm, rd1, rd2, alu_b, alu_y, wd, pc_p4, pc_tgt, mem_q;
  logic        halted_q, illegal_q, eq, take, run, ld_fire;
  ctrl_t       ctl;

  assign ld_ready = rst;
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  assign instr = imem[pc_q[IAW+1:2]];

  rvs_decode u_dec (.instr(instr), .ctl(ctl), .imm(imm));

  rvs_regfile #(.NREG(32), .W(32)) u_rf (
    .clk(clk), .rst(rst), .we(run && ctl.reg_we), .wa(instr[11:7]), .wd(wd),
    .ra1(instr[19:15]), .ra2(instr[24:20]), .ra3(dbg_addr),
    .rd1(rd1), .rd2(rd2), .rd3(dbg_data)
  );

  assign alu_b = ctl.use_imm ? imm : rd2;

  rvs_alu #(.W(32)) u_alu (
    .op(ctl.alu_op), .a(rd1), .b(alu_b), .c(rd2), .y(alu_y), .eq(eq)
  );

  assign mem_q = dmem[alu_y[DAW+1:2]];

  always_ff @(posedge clk) begin
    if (ld_fire && ld_dmem)     dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (run && ctl.mem_wr) dmem[alu_y[DAW+1:2]]   <= rd2;
  end

  assign run    = !rst && !halted_q && !ctl.stop && !ctl.bad;
  assign take   = ctl.jump || (ctl.branch && (eq ^ ctl.br_ne));
  assign pc_p4  = pc_q + 32'd4;
  assign pc_tgt = pc_q + imm;
  assign wd     = ctl.jump ? pc_p4 : (ctl.mem_rd ? mem_q : alu_y);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else if (!halted_q) begin
      if (run) pc_q <= take ? pc_tgt : pc_p4;
      halted_q  <= ctl.stop || ctl.bad;
      illegal_q <= ctl.bad;
    end
  end

  assign pc      = pc_q;
  assign halted  = halted_q;
  assign illegal = illegal_q;

  logic unused_bits;
  assign unused_bits = ^{ld_addr, pc_q[31:IAW+2], pc_q[1:0], alu_y[31:DAW+2], alu_y[1:0]};

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q && pc_q == $past(pc_q));
  // R10
  illegal_halts_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> halted_q);
  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ctl.jump && !ctl.branch) |=> pc_q == $past(pc_q) + 32'd4);
  // R7
  pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);
  // R11
  load_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_ready);
endmodule

// File: tb/sim_rvs_core.sv
`timescale 1ns/1ps
module sim_rvs_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0, ld_dmem = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic        ld_ready, halted, illegal;
  logic [31:0] dbg_data, pc;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  rvs_core u0 (.clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_dmem(ld_dmem), .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .pc(pc), .halted(halted), .illegal(illegal));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, rs1, logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] rs2, rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] rs2, rs1, logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_u(logic [19:0] im, logic [4:0] rd);
    return {im, rd, 7'b0110111};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] im, logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] sx12(logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction
  function automatic logic [19:0] hi_of(logic [31:0] v);
    logic [31:0] t;
    t = v - sx12(v[11:0]);
    return t[31:12];
  endfunction
  function automatic logic [31:0] slt_of(logic [31:0] a, b);
    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(logic dm, int a, logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_dmem = dm; ld_addr = 10'(a); ld_data = d;
  endtask

  task automatic start_load();
    @(negedge clk); rst = 1'b1; ld_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic go_wait();
    @(negedge clk); ld_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
  endtask

  task automatic rd_reg(int r, output logic [31:0] v);
    dbg_addr = 5'(r); #1; v = dbg_data;
  endtask

  task automatic chk_reg(string req, int r, logic [31:0] exp);
    logic [31:0] v;
    rd_reg(r, v);
    chk(req, v, exp);
  endtask

  logic [31:0] arr [5];
  logic [31:0] sum, a, b, u, v;
  logic [11:0] im;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state
    chk("R6 pc", pc, 32'h0);
    chk("R6 halted", {31'b0, halted}, 32'h0);
    chk("R6 illegal", {31'b0, illegal}, 32'h0);
    chk("R11 ready in reset", {31'b0, ld_ready}, 32'h1);
    chk_reg("R6 reg zero", 5, 32'h0);

    // directed: array sum, branches, jal, store/load, stop word
    start_load();
    sum = 0;
    for (int k = 0; k < 5; k++) begin
      arr[k] = $urandom; sum += arr[k];
      put(1, 128 + k, arr[k]);
    end
    put(1, 64, 32'h200);
    put(1, 65, 32'd5);
    put(0, 0,  enc_i(12'd256, 0, 3'b000, 10, 7'b0010011));
    put(0, 1,  enc_i(12'd0, 10, 3'b010, 1, 7'b0000011));
    put(0, 2,  enc_i(12'd4, 10, 3'b010, 2, 7'b0000011));
    put(0, 3,  enc_r(7'd0, 0, 0, 3'b000, 3));
    put(0, 4,  enc_i(12'd0, 1, 3'b010, 4, 7'b0000011));
    put(0, 5,  enc_r(7'd0, 4, 3, 3'b000, 3));
    put(0, 6,  enc_i(12'd4, 1, 3'b000, 1, 7'b0010011));
    put(0, 7,  enc_i(12'hfff, 2, 3'b000, 2, 7'b0010011));
    put(0, 8,  enc_b(13'h1ff0, 0, 2, 3'b001));
    put(0, 9,  enc_s(12'd8, 3, 10));
    put(0, 10, enc_i(12'd8, 10, 3'b010, 5, 7'b0000011));
    put(0, 11, enc_b(13'd8, 0, 0, 3'b000));
    put(0, 12, enc_i(12'd1, 0, 3'b000, 6, 7'b0010011));
    put(0, 13, enc_j(21'd8, 7));
    put(0, 14, enc_i(12'd1, 0, 3'b000, 8, 7'b0010011));
    put(0, 15, enc_i(12'd5, 0, 3'b000, 0, 7'b0010011));
    put(0, 16, enc_i(12'hffc, 1, 3'b010, 11, 7'b0000011));
    put(0, 17, 32'h0000_0073);
    put(0, 18, enc_i(12'd1, 0, 3'b000, 31, 7'b0010011));
    go_wait();
    chk("R11 ready after reset", {31'b0, ld_ready}, 32'h0);
    chk_reg("R2 loop sum", 3, sum);
    chk_reg("R5 store then load", 5, sum);
    chk_reg("R3 decrement to zero", 2, 32'h0);
    chk_reg("R5 pointer walk", 1, 32'h214);
    chk_reg("R5 negative offset", 11, arr[4]);
    chk_reg("R7 beq taken skip", 6, 32'h0);
    chk_reg("R8 jal link", 7, 32'd56);
    chk_reg("R8 jal skip", 8, 32'h0);
    chk_reg("R1 x0 stays zero", 0, 32'h0);
    chk_reg("R9 no exec after stop", 31, 32'h0);
    chk("R9 pc frozen", pc, 32'd68);
    chk("R9 halted", {31'b0, halted}, 32'h1);
    chk("R9 not illegal", {31'b0, illegal}, 32'h0);
    repeat (4) @(negedge clk);
    chk("R9 pc still frozen", pc, 32'd68);

    // directed: illegal opcode
    start_load();
    put(0, 0, enc_i(12'd7, 0, 3'b000, 1, 7'b0010011));
    put(0, 1, 32'h0000_007f);
    put(0, 2, enc_i(12'd9, 0, 3'b000, 2, 7'b0010011));
    go_wait();
    chk("R10 illegal flag", {31'b0, illegal}, 32'h1);
    chk("R10 halted", {31'b0, halted}, 32'h1);
    chk("R10 pc on bad word", pc, 32'd4);
    chk_reg("R10 prior ran", 1, 32'd7);
    chk_reg("R10 later skipped", 2, 32'h0);

    // random and corner ALU trials
    for (int t = 0; t < 40; t++) begin
      case (t)
        0: begin a = 32'h8000_0000; b = 32'h0000_0001; end
        1: begin a = 32'h1234_5678; b = 32'h1234_5678; end
        2: begin a = 32'hffff_ffff; b = 32'h0; end
        3: begin a = 32'h7fff_ffff; b = 32'h8000_0000; end
        default: begin a = $urandom; b = $urandom; end
      endcase
      im = (t == 4) ? 12'h800 : (t == 5) ? 12'h7ff : 12'($urandom);
      u  = (t == 6) ? 32'h0000_ffff : (t == 7) ? 32'h3 : 32'($urandom & 32'hfffff);
      start_load();
      put(0, 0,  enc_u(hi_of(a), 1));
      put(0, 1,  enc_i(a[11:0], 1, 3'b000, 1, 7'b0010011));
      put(0, 2,  enc_u(hi_of(b), 2));
      put(0, 3,  enc_i(b[11:0], 2, 3'b000, 2, 7'b0010011));
      put(0, 4,  enc_r(7'd0, 2, 1, 3'b000, 3));
      put(0, 5,  enc_r(7'b0100000, 2, 1, 3'b000, 4));
      put(0, 6,  enc_r(7'd0, 2, 1, 3'b111, 5));
      put(0, 7,  enc_r(7'd0, 2, 1, 3'b110, 6));
      put(0, 8,  enc_r(7'd0, 2, 1, 3'b010, 7));
      put(0, 9,  enc_r(7'd0, 1, 2, 3'b010, 8));
      put(0, 10, enc_i(im, 1, 3'b000, 9, 7'b0010011));
      put(0, 11, enc_u(u[19:0], 10));
      put(0, 12, enc_r(7'd0, 2, 1, 3'b000, 0));
      put(0, 13, 32'h0000_0073);
      go_wait();
      chk_reg("R4/R3 build a", 1, a);
      chk_reg("R4/R3 build b", 2, b);
      chk_reg("R2 add", 3, a + b);
      chk_reg("R2 sub", 4, a - b);
      chk_reg("R2 and", 5, a & b);
      chk_reg("R2 or", 6, a | b);
      chk_reg("R2 slt ab", 7, slt_of(a, b));
      chk_reg("R2 slt ba", 8, slt_of(b, a));
      chk_reg("R3 addi", 9, a + sx12(im));
      chk_reg("R4 lui", 10, {u[19:0], 12'h000});
      chk_reg("R1 x0 write dropped", 0, 32'h0);
      chk("R9 stop pc", pc, 32'd52);
      // R12: debug port follows address changes in the same cycle
      rd_reg(3, v);
      rd_reg(4, v);
      chk("R12 debug follows", v, a - b);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule